// File: doc/BRIEF.md
# Serial Port Register Bank with Interrupt Identification

This block is the processor-facing register file of an asynchronous serial port. A host reaches it through a 3-bit offset, separate read and write strobes and an 8-bit data bus. Eight offsets hold twelve registers, because a select bit in the line configuration register redirects offsets 0 and 1 to the two bytes of the baud divisor. Read data is combinational from the offset and the current state. Read side effects, such as clearing sticky bits, take effect at the clock edge that ends the read cycle.

The block keeps the interrupt enables and ranks the pending interrupt sources into an identification code. It drives a single interrupt line. Error pulses and line levels come in from the transmit and receive logic and from the modem pins. The block latches them into a line status view and a modem status view, each with sticky bits that are cleared by reading the register. Writes to the FIFO control offset are decoded into an enable, clear strobes and a receive trigger level. The FIFOs and the shift registers are outside the block.

Top module: `ser_reg_bank`

## Requirements
- R1: With LCR bit 7 set, offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes divisor bits 15:8, and neither touches the interrupt enables. With LCR bit 7 clear, offset 1 is the interrupt enable register, bits 3:0 (reads 0 in bits 7:4).
- R2: Offset 3 (LCR) and offset 7 (scratch) read back all 8 written bits. Offset 4 (MCR) keeps bits 4:0, drives them on `modem_ctl`, and reads 0 in bits 7:5.
- R3: A write to offset 2 sets the FIFO enable from bit 0 and the trigger from bits 7:6 (00→1, 01→4, 10→8, 11→14 bytes). `rx_clr`/`tx_clr` pulse during that write cycle when bit 1/bit 2 is set or when bit 0 differs from the current enable.
- R4: Reading offset 2 gives the identification value: bit 0 = 0 when an interrupt is pending, otherwise 1. Bits 2:1 give the source: 11 line status, 10 received data, 01 transmit empty, 00 modem status. Bit 3 is 1 when the received-data source is reported while `rx_timeout` is high. Bits 7:6 read 11 when the FIFOs are enabled and 00 otherwise. Bits 5:4 read 0.
- R5: When several enabled sources are pending, the one reported is line status first, then received data, then transmit empty, then modem status.
- R6: The received-data source (enable bit 0) is pending when `rx_timeout` is high. It is also pending when `rx_level` is nonzero with the FIFOs disabled, or when `rx_level` is at least the trigger with the FIFOs enabled.
- R7: The transmit-empty source (enable bit 1) becomes pending on a rising `thr_empty`, or when enable bit 1 is written from 0 to 1 while `thr_empty` is high. A write to offset 0 with LCR bit 7 clear removes it, and so does a read of offset 2 that reports it.
- R8: Offset 5 (LSR) reads bit 0 `rx_level`≠0, bits 1..4 sticky overrun/parity/framing/break, bit 5 `thr_empty`, bit 6 `tx_idle`, and bit 7 `rx_fifo_err` gated by the FIFO enable. Reading it clears bits 1..4, but an event in the same cycle is kept.
- R9: Offset 6 (MSR) reads bits 7:4 as the present DCD, RI, DSR and CTS levels. Bits 0, 1 and 3 latch any change of CTS, DSR and DCD, and bit 2 latches a falling RI. Reading it clears bits 3:0.
- R10: `irq` is high exactly when identification bit 0 reads 0. The line-status source is pending when enable bit 2 is set and any of LSR bits 1..4 is set. The modem source is pending when enable bit 3 is set and any of MSR bits 3:0 is set.
- R11: After reset the enables, LCR, MCR and scratch are 0, the FIFOs are off, the divisor equals `DIV_RST`, and offset 2 reads 0x01.
- R12: With LCR bit 7 clear, a read of offset 0 returns `rx_data` and pulses `rx_pop`, and a write to offset 0 pulses `tx_push` with `tx_data` equal to the written byte. With LCR bit 7 set, neither strobe pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| rx_data | input | 8 | Oldest received byte |
| rx_level | input | LVL_W | Bytes waiting in receive storage |
| rx_timeout | input | 1 | Character time-out pending |
| ovr_evt | input | 1 | Overrun event pulse |
| par_evt | input | 1 | Parity error event pulse |
| frm_evt | input | 1 | Framing error event pulse |
| brk_evt | input | 1 | Break event pulse |
| rx_fifo_err | input | 1 | Some stored byte carries an error |
| thr_empty | input | 1 | Transmit holding storage empty |
| tx_idle | input | 1 | Transmitter completely empty |
| cts | input | 1 | Clear-to-send level |
| dsr | input | 1 | Data-set-ready level |
| ri | input | 1 | Ring indicator level |
| dcd | input | 1 | Carrier detect level |
| rx_pop | output | 1 | Receive byte consumed |
| tx_push | output | 1 | Transmit byte written |
| tx_data | output | 8 | Byte to transmit |
| divisor | output | 16 | Baud divisor |
| line_cfg | output | 8 | Line configuration register |
| modem_ctl | output | 5 | Modem control bits |
| fifo_on | output | 1 | FIFOs enabled |
| rx_clr | output | 1 | Clear receive FIFO |
| tx_clr | output | 1 | Clear transmit FIFO |
| rx_trig | output | 4 | Receive trigger level in bytes |
| irq | output | 1 | Interrupt request |

## Verification
The ranking is tried first with a single source at a time and then with four sources pending together. Those sources are retired one by one through their own clearing reads, so each identification code and each ranking step can be told apart. The received-data source is checked with the FIFOs off and on. Levels on both sides of the trigger separate the "nonzero" rule from the threshold rule, and a time-out with a low level separates bit 3. The modem lines are changed together and then singly, including a rising and a falling RI, which shows that only the trailing edge is latched.

// File: rtl/ser_reg_bank.sv
module ser_reg_bank #(
  parameter int          LVL_W   = 5,
  parameter logic [15:0] DIV_RST = 16'd1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic [7:0]       rx_data,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_timeout,
  input  logic             ovr_evt,
  input  logic             par_evt,
  input  logic             frm_evt,
  input  logic             brk_evt,
  input  logic             rx_fifo_err,
  input  logic             thr_empty,
  input  logic             tx_idle,
  input  logic             cts,
  input  logic             dsr,
  input  logic             ri,
  input  logic             dcd,
  output logic             rx_pop,
  output logic             tx_push,
  output logic [7:0]       tx_data,
  output logic [15:0]      divisor,
  output logic [7:0]       line_cfg,
  output logic [4:0]       modem_ctl,
  output logic             fifo_on,
  output logic             rx_clr,
  output logic             tx_clr,
  output logic [3:0]       rx_trig,
  output logic             irq
);

  localparam logic [2:0] A_DATA = 3'd0, A_IER = 3'd1, A_IIR = 3'd2, A_LCR = 3'd3,
                         A_MCR  = 3'd4, A_LSR = 3'd5, A_MSR = 3'd6, A_SCR = 3'd7;

  logic [3:0] ier;
  logic [7:0] lcr, scr, dll, dlm;
  logic [4:0] mcr;
  logic       fifo_en;
  logic [1:0] trig_sel;
  logic [3:0] lsr_err;
  logic [3:0] msr_d;
  logic       cts_q, dsr_q, ri_q, dcd_q, seen;
  logic       thr_q, thre_pend;

  wire dlab = lcr[7];
  wire wr_data = wr_en && addr == A_DATA;
  wire wr_ier  = wr_en && addr == A_IER;
  wire wr_fcr  = wr_en && addr == A_IIR;
  wire rd_iir  = rd_en && addr == A_IIR;
  wire rd_lsr  = rd_en && addr == A_LSR;
  wire rd_msr  = rd_en && addr == A_MSR;

  assign tx_push   = wr_data && !dlab;
  assign tx_data   = wdata;
  assign rx_pop    = rd_en && addr == A_DATA && !dlab;
  assign divisor   = {dlm, dll};
  assign line_cfg  = lcr;
  assign modem_ctl = mcr;
  assign fifo_on   = fifo_en;
  assign rx_clr    = wr_fcr && (wdata[1] || (wdata[0] != fifo_en));
  assign tx_clr    = wr_fcr && (wdata[2] || (wdata[0] != fifo_en));

  always_comb begin
    case (trig_sel)
      2'd0:    rx_trig = 4'd1;
      2'd1:    rx_trig = 4'd4;
      2'd2:    rx_trig = 4'd8;
      default: rx_trig = 4'd14;
    endcase
  end

  wire [LVL_W-1:0] trig_ext = {{(LVL_W-4){1'b0}}, rx_trig};
  wire rx_any  = rx_level != '0;
  wire rx_hit  = fifo_en ? (rx_level >= trig_ext) : rx_any;

  wire src_ls = ier[2] && (lsr_err != 4'd0);
  wire src_rx = ier[0] && (rx_hit || rx_timeout);
  wire src_tx = ier[1] && thre_pend;
  wire src_ms = ier[3] && (msr_d != 4'd0);
  wire pending = src_ls || src_rx || src_tx || src_ms;

  logic [2:0] iid;
  always_comb begin
    if (src_ls)      iid = 3'b011;
    else if (src_rx) iid = {rx_timeout, 2'b10};
    else if (src_tx) iid = 3'b001;
    else             iid = 3'b000;
  end

  wire [7:0] iir = {fifo_en, fifo_en, 2'b00, iid, !pending};
  assign irq = pending;

  wire [7:0] lsr = {fifo_en && rx_fifo_err, tx_idle, thr_empty, lsr_err, rx_any};
  wire [7:0] msr = {dcd, ri, dsr, cts, msr_d};

  wire [3:0] lsr_new = {brk_evt, frm_evt, par_evt, ovr_evt};
  wire [3:0] msr_new = seen ? {dcd ^ dcd_q, ri_q && !ri, dsr ^ dsr_q, cts ^ cts_q} : 4'd0;

  wire thre_set = (thr_empty && !thr_q) || (wr_ier && !dlab && wdata[1] && !ier[1] && thr_empty);
  wire thre_clr = tx_push || (rd_iir && pending && iid == 3'b001);

  always_comb begin
    case (addr)
      A_DATA:  rdata = dlab ? dll : rx_data;
      A_IER:   rdata = dlab ? dlm : {4'b0000, ier};
      A_IIR:   rdata = iir;
      A_LCR:   rdata = lcr;
      A_MCR:   rdata = {3'b000, mcr};
      A_LSR:   rdata = lsr;
      A_MSR:   rdata = msr;
      default: rdata = scr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier <= '0;
      lcr <= '0;
      mcr <= '0;
      scr <= '0;
      dll <= DIV_RST[7:0];
      dlm <= DIV_RST[15:8];
      fifo_en  <= 1'b0;
      trig_sel <= 2'd0;
    end else if (wr_en) begin
      case (addr)
        A_DATA: if (dlab) dll <= wdata;
        A_IER:  if (dlab) dlm <= wdata; else ier <= wdata[3:0];
        A_IIR: begin
          fifo_en  <= wdata[0];
          trig_sel <= wdata[7:6];
        end
        A_LCR:  lcr <= wdata;
        A_MCR:  mcr <= wdata[4:0];
        A_SCR:  scr <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsr_err <= '0;
      msr_d   <= '0;
      cts_q   <= 1'b0;
      dsr_q   <= 1'b0;
      ri_q    <= 1'b0;
      dcd_q   <= 1'b0;
      seen    <= 1'b0;
    end else begin
      lsr_err <= (rd_lsr ? 4'd0 : lsr_err) | lsr_new;
      msr_d   <= (rd_msr ? 4'd0 : msr_d) | msr_new;
      cts_q   <= cts;
      dsr_q   <= dsr;
      ri_q    <= ri;
      dcd_q   <= dcd;
      seen    <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q     <= 1'b1;
      thre_pend <= 1'b0;
    end else begin
      thr_q <= thr_empty;
      if (thre_clr)      thre_pend <= 1'b0;
      else if (thre_set) thre_pend <= 1'b1;
    end
  end

  a_r1_div_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DATA && dlab) |=> divisor[7:0] == $past(wdata));

  a_r1_ier_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_IER && dlab) |=> ier == $past(ier));

  a_r5_line_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ier[2] && lsr[4:1] != 4'd0) |-> (irq && rdata_iir_low() == 4'b0110));

  a_r8_lsr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr && lsr_new == 4'd0) |=> lsr[4:1] == 4'd0);

  a_r9_msr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_msr && msr_new == 4'd0) |=> msr[3:0] == 4'd0);

  a_r7_thr_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |=> !thre_pend);

  function automatic logic [3:0] rdata_iir_low();
    return iir[3:0];
  endfunction

endmodule

// File: tb/sim_ser_reg_bank.sv
module sim_ser_reg_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, rdata, rx_data = '0, tx_data, line_cfg;
  logic [4:0] rx_level = '0, modem_ctl;
  logic rx_timeout = 0, ovr_evt = 0, par_evt = 0, frm_evt = 0, brk_evt = 0, rx_fifo_err = 0;
  logic thr_empty = 1'b1, tx_idle = 1'b1;
  logic cts = 0, dsr = 0, ri = 0, dcd = 0;
  logic rx_pop, tx_push, fifo_on, rx_clr, tx_clr, irq;
  logic [15:0] divisor;
  logic [3:0] rx_trig;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ser_reg_bank u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .rdata(rdata), .rx_data(rx_data), .rx_level(rx_level), .rx_timeout(rx_timeout),
    .ovr_evt(ovr_evt), .par_evt(par_evt), .frm_evt(frm_evt), .brk_evt(brk_evt),
    .rx_fifo_err(rx_fifo_err), .thr_empty(thr_empty), .tx_idle(tx_idle),
    .cts(cts), .dsr(dsr), .ri(ri), .dcd(dcd), .rx_pop(rx_pop), .tx_push(tx_push),
    .tx_data(tx_data), .divisor(divisor), .line_cfg(line_cfg), .modem_ctl(modem_ctl),
    .fifo_on(fifo_on), .rx_clr(rx_clr), .tx_clr(tx_clr), .rx_trig(rx_trig), .irq(irq));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fcr_wr(input logic [7:0] d, input logic exp_rc, input logic exp_tc, input string tag);
    @(negedge clk);
    addr = 3'd2; wdata = d; wr_en = 1'b1;
    #1;
    chk({tag, " rx_clr"}, 16'(rx_clr), 16'(exp_rc));
    chk({tag, " tx_clr"}, 16'(tx_clr), 16'(exp_tc));
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d, output logic pop);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1;
    d = rdata; pop = rx_pop;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] d;
    logic p;
    rd(a, d, p);
    chk(tag, 16'(d), 16'(exp));
  endtask

  task automatic iir_chk(input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = 3'd2;
    #1;
    chk({tag, " R4 iir"}, 16'(rdata), 16'(exp));
    chk({tag, " R10 irq"}, 16'(irq), 16'(!exp[0]));
  endtask

  task automatic t_reset();
    rd_chk(3'd1, 8'h00, "R11 ier");
    rd_chk(3'd2, 8'h01, "R11 iir");
    rd_chk(3'd3, 8'h00, "R11 lcr");
    rd_chk(3'd4, 8'h00, "R11 mcr");
    rd_chk(3'd7, 8'h00, "R11 scr");
    rd_chk(3'd5, 8'h60, "R11 lsr");
    rd_chk(3'd6, 8'h00, "R11 msr");
    chk("R11 divisor", divisor, 16'h0001);
    chk("R11 fifo_on", 16'(fifo_on), 16'h0);
    chk("R11 irq", 16'(irq), 16'h0);
  endtask

  task automatic t_regs();
    wr(3'd7, 8'hA5); rd_chk(3'd7, 8'hA5, "R2 scratch");
    wr(3'd7, 8'h5A); rd_chk(3'd7, 8'h5A, "R2 scratch second");
    wr(3'd4, 8'hFF); rd_chk(3'd4, 8'h1F, "R2 mcr");
    chk("R2 modem_ctl", 16'(modem_ctl), 16'h1F);
    wr(3'd4, 8'h00);
    wr(3'd3, 8'h1B); rd_chk(3'd3, 8'h1B, "R2 lcr");
    chk("R2 line_cfg", 16'(line_cfg), 16'h1B);
  endtask

  task automatic t_dlab();
    logic [7:0] d;
    logic p;
    wr(3'd3, 8'h83);
    wr(3'd0, 8'h34);
    wr(3'd1, 8'h12);
    chk("R1 divisor", divisor, 16'h1234);
    rx_data = 8'h5A;
    rd(3'd0, d, p);
    chk("R1 read dll", 16'(d), 16'h34);
    chk("R12 no pop under dlab", 16'(p), 16'h0);
    rd_chk(3'd1, 8'h12, "R1 read dlm");
    wr(3'd3, 8'h03);
    rd_chk(3'd1, 8'h00, "R1 ier untouched");
    rd(3'd0, d, p);
    chk("R12 rx data", 16'(d), 16'h5A);
    chk("R12 pop", 16'(p), 16'h1);
    @(negedge clk);
    addr = 3'd0; wdata = 8'hC3; wr_en = 1'b1;
    #1;
    chk("R12 push", 16'(tx_push), 16'h1);
    chk("R12 tx_data", 16'(tx_data), 16'hC3);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R1 divisor kept", divisor, 16'h1234);
  endtask

  task automatic t_fifo();
    fcr_wr(8'hC7, 1'b1, 1'b1, "R3 enable clear");
    chk("R3 fifo_on", 16'(fifo_on), 16'h1);
    chk("R3 trig 14", 16'(rx_trig), 16'd14);
    iir_chk(8'hC1, "R3 enabled");
    fcr_wr(8'h41, 1'b0, 1'b0, "R3 no toggle");
    chk("R3 trig 4", 16'(rx_trig), 16'd4);
    fcr_wr(8'h83, 1'b1, 1'b0, "R3 rx only");
    chk("R3 trig 8", 16'(rx_trig), 16'd8);
    fcr_wr(8'h05, 1'b0, 1'b1, "R3 tx only");
    chk("R3 trig 1", 16'(rx_trig), 16'd1);
    fcr_wr(8'h00, 1'b1, 1'b1, "R3 disable");
    chk("R3 fifo off", 16'(fifo_on), 16'h0);
    iir_chk(8'h01, "R3 disabled");
  endtask

  task automatic t_rx();
    wr(3'd1, 8'h01);
    iir_chk(8'h01, "R6 empty");
    rx_level = 5'd1;
    iir_chk(8'h04, "R6 nonzero no fifo");
    fcr_wr(8'h81, 1'b1, 1'b1, "R6 fifo on");
    rx_level = 5'd7;
    iir_chk(8'hC1, "R6 below trigger");
    rx_level = 5'd8;
    iir_chk(8'hC4, "R6 at trigger");
    rx_level = 5'd3; rx_timeout = 1'b1;
    iir_chk(8'hCC, "R6 timeout");
    rx_level = 5'd0; rx_timeout = 1'b0;
    fcr_wr(8'h00, 1'b1, 1'b1, "R6 fifo off");
    wr(3'd1, 8'h00);
  endtask

  task automatic t_thre();
    wr(3'd1, 8'h02);
    iir_chk(8'h02, "R7 enable while empty");
    rd_chk(3'd2, 8'h02, "R7 iir read reports");
    iir_chk(8'h01, "R7 cleared by iir read");
    wr(3'd0, 8'h11);
    thr_empty = 1'b0;
    @(negedge clk);
    thr_empty = 1'b1;
    @(negedge clk);
    iir_chk(8'h02, "R7 rising empty");
    wr(3'd0, 8'h22);
    iir_chk(8'h01, "R7 cleared by write");
    wr(3'd1, 8'h00);
  endtask

  task automatic t_lsr();
    @(negedge clk); ovr_evt = 1'b1;
    @(negedge clk); ovr_evt = 1'b0;
    rd_chk(3'd5, 8'h62, "R8 overrun");
    rd_chk(3'd5, 8'h60, "R8 cleared");
    @(negedge clk); par_evt = 1'b1; frm_evt = 1'b1; brk_evt = 1'b1;
    @(negedge clk); par_evt = 1'b0; frm_evt = 1'b0; brk_evt = 1'b0;
    rd_chk(3'd5, 8'h7C, "R8 par frm brk");
    rd_chk(3'd5, 8'h60, "R8 cleared again");
    rx_fifo_err = 1'b1;
    rd_chk(3'd5, 8'h60, "R8 fifo err gated");
    fcr_wr(8'h01, 1'b1, 1'b1, "R8 fifo on");
    rx_level = 5'd2;
    rd_chk(3'd5, 8'hE1, "R8 fifo err and ready");
    rx_level = 5'd0; rx_fifo_err = 1'b0;
    fcr_wr(8'h00, 1'b1, 1'b1, "R8 fifo off");
    tx_idle = 1'b0;
    rd_chk(3'd5, 8'h20, "R8 tx busy");
    tx_idle = 1'b1;
  endtask

  task automatic t_prio();
    @(negedge clk); cts = 1'b1;
    @(negedge clk);
    wr(3'd1, 8'h0F);
    iir_chk(8'h02, "R5 tx over modem");
    rx_level = 5'd1;
    iir_chk(8'h04, "R5 rx over tx");
    @(negedge clk); ovr_evt = 1'b1;
    @(negedge clk); ovr_evt = 1'b0;
    iir_chk(8'h06, "R5 line over all");
    rd_chk(3'd5, 8'h63, "R5 lsr read");
    iir_chk(8'h04, "R5 after lsr read");
    rx_level = 5'd0;
    iir_chk(8'h02, "R5 after rx drain");
    rd_chk(3'd2, 8'h02, "R5 iir read");
    iir_chk(8'h00, "R5 modem last");
    rd_chk(3'd6, 8'h11, "R9 cts delta");
    iir_chk(8'h01, "R5 none");
    wr(3'd1, 8'h00);
  endtask

  task automatic t_msr();
    @(negedge clk); dsr = 1'b1; ri = 1'b1; dcd = 1'b1;
    @(negedge clk);
    rd_chk(3'd6, 8'hFA, "R9 rise no teri");
    rd_chk(3'd6, 8'hF0, "R9 cleared");
    @(negedge clk); ri = 1'b0;
    @(negedge clk);
    rd_chk(3'd6, 8'hB4, "R9 trailing ri");
    rd_chk(3'd6, 8'hB0, "R9 cleared again");
    @(negedge clk); cts = 1'b0;
    @(negedge clk);
    rd_chk(3'd6, 8'hA1, "R9 cts fall");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_dlab();
    t_fifo();
    t_rx();
    t_thre();
    t_lsr();
    t_prio();
    t_msr();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule